// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It frames each character as a low start bit, then the data bits with the least significant first, then an optional parity bit, then a high stop bit. Two sampling schemes are available. With the line-rate option, the receiver watches for a falling edge on a sixteen-times enable. It confirms that the edge is a real start bit, and then decides each bit by a majority vote over three samples taken around the middle of the bit. With the clocked option, the receiver samples the line once on each rising edge of an external bit clock.

Each finished character goes into a single holding register. A status word reports it together with ready, parity-error, framing-error, break and overrun flags. A request-to-send output shows that a character is waiting, unless software has taken direct control of that pin. An interrupt line is raised while a character is waiting and interrupts are enabled. A read strobe consumes the character.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rd_word` is all zero, `irq` is 0, and `rts` is 0 when `rts_sw_mode` is 0.
- R2: In 16x mode (`mode_1x`=0), a well-formed frame is delivered as `rd_word[7:0]`, with data received LSB first and `rd_word[8]` (ready) set to 1.
- R3: In 16x mode, each bit is the 2-of-3 majority of samples 7, 8 and 9 of that bit. Sample 0 is the tick on which the falling edge is seen. A single wrong sample among them does not change the received value.
- R4: In 16x mode, if the line is high at sample 8 of a start bit, the receiver drops the frame and returns to hunting. No character is delivered.
- R5: In 1x mode (`mode_1x`=1), the line is sampled once per rising edge of `bit_clk`, and a frame is delivered with the same word layout as in R2.
- R6: With `par_en`=1, a parity bit follows the data. `rd_word[9]` is set when the parity disagrees with the chosen sense: `par_odd`=0 means the data and parity together hold an even number of ones, and `par_odd`=1 means an odd number.
- R7: `rd_word[10]` (frame error) is set when the stop bit is received as 0.
- R8: `rd_word[11]` (break) is set when all data bits, the parity bit (if enabled) and the stop bit are 0. A break always also shows frame error and zero data.
- R9: `irq` is high while ready is set and `irq_en` is 1. With `rts_sw_mode`=0, `rts` follows ready. With `rts_sw_mode`=1, `rts` follows `rts_sw_val`.
- R10: A cycle with `rd_stb` high clears the ready and overrun flags, which drops `irq` and the ready-driven `rts`.
- R11: If a character completes while ready is still set and no read happens in that cycle, the new character replaces the old one and `rd_word[12]` (overrun) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at sixteen times the bit rate (16x mode) |
| bit_clk | input | 1 | External bit clock, sampled on its rising edge (1x mode) |
| rxd | input | 1 | Serial line, idle high |
| mode_1x | input | 1 | 0: 16x voted sampling, 1: clocked sampling |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| irq_en | input | 1 | Interrupt enable |
| rts_sw_mode | input | 1 | 1: rts driven from rts_sw_val |
| rts_sw_val | input | 1 | Software level for rts |
| rd_stb | input | 1 | Read strobe, consumes the held character |
| rd_word | output | 16 | {3'b0, overrun, break, frame err, parity err, ready, data[7:0]} |
| rts | output | 1 | Ready indicator or software level |
| irq | output | 1 | Character-ready interrupt |

## Verification
The hardest cases to produce are the ones that depend on the position of a sample inside a bit. These are the start bit that turns high again before its sample 8, and the single corrupted sample inside a voting window. The bench therefore drives the line one oversampling tick at a time. Each tick is generated by the bench itself, so it can flip exactly one chosen sample of a chosen bit, or end a low pulse at a chosen sample count. The overrun case needs two characters to arrive with no read in between. The bench gets there by turning off its automatic reader and reading once, by hand, after the second frame.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int CW    = $clog2(OVS),
  localparam int BW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bit_clk,
  input  logic              rxd,
  input  logic              mode_1x,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              rts_sw_mode,
  input  logic              rts_sw_val,
  input  logic              rd_stb,
  output logic [DATA_W+7:0] rd_word,
  output logic              rts,
  output logic              irq
);
  localparam logic [2:0] S_HUNT = 3'd0, S_START = 3'd1, S_DATA = 3'd2,
                         S_PAR  = 3'd3, S_STOP  = 3'd4;
  localparam logic [CW-1:0] C7   = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] C8   = CW'(OVS/2);
  localparam logic [CW-1:0] C9   = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] CEND = CW'(OVS - 1);
  localparam logic [BW-1:0] NLAST = BW'(DATA_W - 1);

  logic [1:0] rx_sy, bc_sy;
  logic bc_q, rx_last, s7, s8, vbit, pbit;
  logic [2:0] st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nb;
  logic [DATA_W-1:0] sh, dat;
  logic rdy, pe, fe, brk, ovr;

  wire rx_s    = rx_sy[1];
  wire bc_rise = bc_sy[1] & ~bc_q;
  wire ev      = mode_1x ? bc_rise : tick;
  wire maj_now = (s7 & s8) | (s7 & rx_s) | (s8 & rx_s);
  wire bit_end = mode_1x ? ev : (ev && (st == S_STOP ? cnt == C9 : cnt == CEND));
  wire bval    = mode_1x ? rx_s : (st == S_STOP ? maj_now : vbit);
  wire fire    = ev && st == S_HUNT && !rx_s && rx_last;
  wire done    = bit_end && st == S_STOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sy <= 2'b11; bc_sy <= 2'b00; bc_q <= 1'b0;
    end else begin
      rx_sy <= {rx_sy[0], rxd};
      bc_sy <= {bc_sy[0], bit_clk};
      bc_q  <= bc_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_last <= 1'b1; cnt <= '0; s7 <= 1'b1; s8 <= 1'b1; vbit <= 1'b1;
    end else if (ev) begin
      rx_last <= rx_s;
      if (!mode_1x) begin
        if (fire) cnt <= CW'(1);
        else if (st != S_HUNT) cnt <= cnt + CW'(1);
        if (cnt == C7) s7 <= rx_s;
        if (cnt == C8) s8 <= rx_s;
        if (cnt == C9) vbit <= maj_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT; nb <= '0; sh <= '0; pbit <= 1'b0;
    end else begin
      case (st)
        S_HUNT: if (fire) begin
          st <= mode_1x ? S_DATA : S_START;
          nb <= '0;
          pbit <= 1'b0;
        end
        S_START: begin
          if (ev && cnt == C8 && rx_s) st <= S_HUNT;
          else if (bit_end) st <= S_DATA;
        end
        S_DATA: if (bit_end) begin
          sh <= {bval, sh[DATA_W-1:1]};
          nb <= nb + BW'(1);
          if (nb == NLAST) st <= par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (bit_end) begin
          pbit <= bval;
          st   <= S_STOP;
        end
        S_STOP: if (bit_end) st <= S_HUNT;
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= '0; rdy <= 1'b0; pe <= 1'b0; fe <= 1'b0; brk <= 1'b0; ovr <= 1'b0;
    end else if (done) begin
      dat <= sh;
      pe  <= par_en && ((^sh ^ pbit) != par_odd);
      fe  <= !bval;
      brk <= !bval && sh == '0 && !(par_en && pbit);
      ovr <= rdy && !rd_stb;
      rdy <= 1'b1;
    end else if (rd_stb) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end

  assign rd_word = {3'b000, ovr, brk, fe, pe, rdy, dat};
  assign rts     = rts_sw_mode ? rts_sw_val : rdy;
  assign irq     = irq_en & rdy;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic          done,
  input logic          irq,
  input logic          irq_en,
  input logic          tick,
  input logic          mode_1x,
  input logic          rx_s,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt,
  input logic [15:0]   rd_word
);
  localparam logic [CW-1:0] C8 = CW'(1 << (CW - 1));

  // R2
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_word[8]);
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done) |=> (!rd_word[8] && !rd_word[12]));
  // R11
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_word[8] && !rd_stb) |=> rd_word[12]);
  // R8
  break_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[11] |-> (rd_word[10] && rd_word[7:0] == 8'h00));
  // R4
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && tick && !mode_1x && cnt == C8 && rx_s) |=> st == 3'd0);
  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_en);
endmodule

bind serial_rx_core serial_rx_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .done(done), .irq(irq),
  .irq_en(irq_en), .tick(tick), .mode_1x(mode_1x), .rx_s(rx_s),
  .st(st), .cnt(cnt), .rd_word(rd_word)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, bit_clk = 1'b0, rxd = 1'b1;
  logic mode_1x = 1'b0, par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b1;
  logic rts_sw_mode = 1'b0, rts_sw_val = 1'b0, rd_stb = 1'b0;
  logic [15:0] rd_word;
  logic rts, irq;
  logic auto_rd = 1'b1;
  int nchk = 0, nerr = 0;
  logic [15:0] expq[$];
  string tagq[$];

  serial_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_clk(bit_clk), .rxd(rxd),
    .mode_1x(mode_1x), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .rts_sw_mode(rts_sw_mode), .rts_sw_val(rts_sw_val), .rd_stb(rd_stb),
    .rd_word(rd_word), .rts(rts), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ew(logic [7:0] d, bit ov, bit bk, bit f, bit p);
    return {3'b000, ov, bk, f, p, 1'b1, d};
  endfunction

  task automatic expect_char(string tag, logic [15:0] w);
    expq.push_back(w);
    tagq.push_back(tag);
  endtask

  task automatic samp(bit v);
    @(negedge clk) rxd = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic bit16(bit v, int g);
    for (int s = 0; s < 16; s++) samp((s == g) ? !v : v);
  endtask

  task automatic fr16(logic [7:0] d, bit up, bit pb, bit sb, int g, int gbit);
    bit16(1'b0, -1);
    for (int i = 0; i < 8; i++) bit16(d[i], (i == gbit) ? g : -1);
    if (up) bit16(pb, -1);
    bit16(sb, -1);
    for (int i = 0; i < 20; i++) samp(1'b1);
  endtask

  task automatic b1(bit v);
    @(negedge clk) begin bit_clk = 1'b0; rxd = v; end
    repeat (8) @(negedge clk);
    bit_clk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic fr1(logic [7:0] d, bit up, bit pb);
    b1(1'b1); b1(1'b1); b1(1'b0);
    for (int i = 0; i < 8; i++) b1(d[i]);
    if (up) b1(pb);
    b1(1'b1); b1(1'b1); b1(1'b1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && rd_word[8] && !rd_stb) begin
        if (expq.size() == 0) chk("unexpected character", {16'h0, rd_word}, 32'h0);
        else chk(tagq.pop_front(), {16'h0, rd_word}, {16'h0, expq.pop_front()});
        rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk("R1 word", {16'h0, rd_word}, 32'h0);
    chk("R1 irq/rts", {30'h0, irq, rts}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2
    expect_char("R2 A5", ew(8'hA5, 0, 0, 0, 0)); fr16(8'hA5, 0, 0, 1, -1, -1);
    expect_char("R2 3C", ew(8'h3C, 0, 0, 0, 0)); fr16(8'h3C, 0, 0, 1, -1, -1);
    // R3
    expect_char("R3 glitch s8", ew(8'h0F, 0, 0, 0, 0)); fr16(8'h0F, 0, 0, 1, 8, 0);
    expect_char("R3 glitch s7", ew(8'hF0, 0, 0, 0, 0)); fr16(8'hF0, 0, 0, 1, 7, 5);
    expect_char("R3 glitch s9", ew(8'h96, 0, 0, 0, 0)); fr16(8'h96, 0, 0, 1, 9, 2);
    // R4
    for (int i = 0; i < 6; i++) samp(1'b0);
    for (int i = 0; i < 40; i++) samp(1'b1);
    chk("R4 no char", {31'h0, rd_word[8]}, 32'h0);
    expect_char("R4 resync", ew(8'h6D, 0, 0, 0, 0)); fr16(8'h6D, 0, 0, 1, -1, -1);
    // R6
    par_en = 1'b1; par_odd = 1'b0;
    expect_char("R6 even ok", ew(8'h5A, 0, 0, 0, 0)); fr16(8'h5A, 1, 0, 1, -1, -1);
    expect_char("R6 even bad", ew(8'h5A, 0, 0, 0, 1)); fr16(8'h5A, 1, 1, 1, -1, -1);
    par_odd = 1'b1;
    expect_char("R6 odd ok", ew(8'h01, 0, 0, 0, 0)); fr16(8'h01, 1, 0, 1, -1, -1);
    expect_char("R6 odd bad", ew(8'h01, 0, 0, 0, 1)); fr16(8'h01, 1, 1, 1, -1, -1);
    par_en = 1'b0; par_odd = 1'b0;
    // R7
    expect_char("R7 frame", ew(8'h55, 0, 0, 1, 0)); fr16(8'h55, 0, 0, 0, -1, -1);
    // R8
    expect_char("R8 break", ew(8'h00, 0, 1, 1, 0)); fr16(8'h00, 0, 0, 0, -1, -1);
    expect_char("R8 zero ok", ew(8'h00, 0, 0, 0, 0)); fr16(8'h00, 0, 0, 1, -1, -1);
    // R5
    mode_1x = 1'b1;
    expect_char("R5 1x C3", ew(8'hC3, 0, 0, 0, 0)); fr1(8'hC3, 0, 0);
    par_en = 1'b1;
    expect_char("R5 1x par", ew(8'h07, 0, 0, 0, 1)); fr1(8'h07, 1, 0);
    par_en = 1'b0; mode_1x = 1'b0;
    repeat (10) @(negedge clk);

    // R9
    auto_rd = 1'b0;
    fr16(8'h81, 0, 0, 1, -1, -1);
    chk("R9 held word", {16'h0, rd_word}, {16'h0, ew(8'h81, 0, 0, 0, 0)});
    chk("R9 irq/rts on", {30'h0, irq, rts}, 32'h3);
    rts_sw_mode = 1'b1; rts_sw_val = 1'b0;
    @(negedge clk) chk("R9 sw rts 0", {31'h0, rts}, 32'h0);
    rts_sw_val = 1'b1;
    @(negedge clk) chk("R9 sw rts 1", {31'h0, rts}, 32'h1);
    rts_sw_mode = 1'b0; irq_en = 1'b0;
    @(negedge clk) chk("R9 irq masked", {31'h0, irq}, 32'h0);
    irq_en = 1'b1;
    // R11
    fr16(8'h7E, 0, 0, 1, -1, -1);
    chk("R11 overrun", {16'h0, rd_word}, {16'h0, ew(8'h7E, 1, 0, 0, 0)});
    // R10
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    chk("R10 flags cleared", {30'h0, rd_word[12], rd_word[8]}, 32'h0);
    chk("R10 irq/rts off", {30'h0, irq, rts}, 32'h0);
    auto_rd = 1'b1;

    chk("R2 all delivered", expq.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule